// File: doc/BRIEF.md
# Data Address Breakpoint Checker

This block sits beside the load/store path and compares every data access against one programmable breakpoint address. An access is described by its address, its size (1, 2, 4, 8 or 16 bytes) and its direction. The compare ignores the low address bits covered by the access size, so any access whose aligned span covers the breakpoint byte counts as a match. The match is then qualified by one of two enables, one for reads and one for writes. A qualified match is reported at once on `hit` and latched into a sticky trap flag that software clears.

The block also produces the address that the memory system should use. In little-endian mode this is the issued address unchanged. In big-endian mode the three lowest bits are inverted and then aligned to the access size. The breakpoint compare always uses the address as issued, never the adjusted one.

The breakpoint address and the control bits are loaded through a single write port with a one-bit register select.

Top module: `dbrk_watch`

## Requirements
- R1: After reset the breakpoint address is 0, both enables are off, the mode is little-endian and `trapFlag` is 0. With these settings a byte read of address 0 gives no hit.
- R2: A write with `cfgSel`=0 loads `cfgWrData` into the breakpoint address. A write with `cfgSel`=1 loads the control bits from `cfgWrData`: bit 0 is the read enable, bit 1 the write enable and bit 2 big-endian mode. Writing 1 to bit 3 clears `trapFlag`.
- R3: `accSize` codes 0, 1, 2, 3 and 4 mean 1, 2, 4, 8 and 16 bytes, and the compare ignores the lowest `accSize` address bits. Codes above 4 behave as 16 bytes. All higher bits must be equal.
- R4: A read (`accWrite`=0) whose address matches raises `hit` only while the read enable is set.
- R5: A write (`accWrite`=1) whose address matches raises `hit` only while the write enable is set.
- R6: `hit` is combinational in the cycle of the access and is 0 whenever `accValid` is 0.
- R7: `trapFlag` becomes 1 at the clock edge that samples `hit`=1. It stays 1 until a control write with bit 3 set clears it. If a hit and a clear fall in the same cycle, the hit wins.
- R8: In little-endian mode `adjAddr` equals `accAddr`.
- R9: In big-endian mode `adjAddr[2:0]` is `~accAddr[2:0]` with the bits below the access alignment forced to 0, and the upper bits pass unchanged. The compare still uses the unadjusted `accAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgSel | input | 1 | 0 = breakpoint address, 1 = control bits |
| cfgWrData | input | ADDR_W | Write data |
| accValid | input | 1 | An access is presented this cycle |
| accWrite | input | 1 | 1 = store, 0 = load |
| accSize | input | 3 | Size code, 2^code bytes |
| accAddr | input | ADDR_W | Access address as issued |
| adjAddr | output | ADDR_W | Address after endian adjustment |
| hit | output | 1 | Qualified breakpoint match this cycle |
| trapFlag | output | 1 | Sticky data-access trap status |

## Verification
Each size code is driven with one address inside its aligned span and one address just outside it around the same breakpoint. Together these show that exactly the right number of low bits is ignored, no more and no fewer. A byte access that differs from the breakpoint only in a high bit shows that the upper compare is never masked. Loads and stores that match are replayed under read-only, write-only and neither enable to separate the two gates. Big-endian accesses of every size check the inverted and aligned low bits. A big-endian access whose adjusted address would equal the breakpoint, while its issued address does not, proves that the compare uses the issued address.

// File: rtl/dbrk_pkg.sv
package dbrk_pkg;
  // Control register bit positions
  localparam int CTL_RD_EN   = 0;
  localparam int CTL_WR_EN   = 1;
  localparam int CTL_BIG_END = 2;
  localparam int CTL_TRAP_CLR = 3;
  // Widest access spans 2^MAX_IGNORE bytes
  localparam int MAX_IGNORE  = 4;

  typedef struct packed {
    logic loadBp;
    logic bigEndian;
  } dpStrobe_t;
endpackage

// File: rtl/dbrk_datapath.sv
module dbrk_datapath
  import dbrk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [SIZE_W-1:0] accSize,
  output logic              addrMatch,
  output logic [ADDR_W-1:0] adjAddr
);
  localparam int HI_W = ADDR_W - MAX_IGNORE;

  logic [ADDR_W-1:0]     bpAddr;
  logic [MAX_IGNORE-1:0] ignoreBit;
  logic [ADDR_W-1:0]     cmpMask;
  logic [2:0]            beLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             bpAddr <= '0;
    else if (strobe.loadBp) bpAddr <= cfgWrData;
  end

  // one ignore flag per low address bit, set when the size spans it
  for (genvar i = 0; i < MAX_IGNORE; i++) begin : g_ign
    assign ignoreBit[i] = (32'(accSize) > i);
  end

  assign cmpMask   = {{HI_W{1'b1}}, ~ignoreBit};
  assign addrMatch = (((accAddr ^ bpAddr) & cmpMask) == '0);

  assign beLow   = ~accAddr[2:0] & ~ignoreBit[2:0];
  assign adjAddr = strobe.bigEndian ? {accAddr[ADDR_W-1:3], beLow} : accAddr;
endmodule

// File: rtl/dbrk_ctrl.sv
module dbrk_ctrl
  import dbrk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgWrEn,
  input  logic      cfgSel,
  input  logic [3:0] cfgBits,
  input  logic      accValid,
  input  logic      accWrite,
  input  logic      addrMatch,
  output dpStrobe_t strobe,
  output logic      hit,
  output logic      trapFlag
);
  logic rdEn, wrEn, bigEnd;
  logic ctlWrite, clrReq;

  assign ctlWrite = cfgWrEn && cfgSel;
  assign clrReq   = ctlWrite && cfgBits[CTL_TRAP_CLR];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdEn   <= 1'b0;
      wrEn   <= 1'b0;
      bigEnd <= 1'b0;
    end else if (ctlWrite) begin
      rdEn   <= cfgBits[CTL_RD_EN];
      wrEn   <= cfgBits[CTL_WR_EN];
      bigEnd <= cfgBits[CTL_BIG_END];
    end
  end

  assign hit = accValid && addrMatch && (accWrite ? wrEn : rdEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       trapFlag <= 1'b0;
    else if (hit)    trapFlag <= 1'b1;
    else if (clrReq) trapFlag <= 1'b0;
  end

  always_comb begin
    strobe.loadBp    = cfgWrEn && !cfgSel;
    strobe.bigEndian = bigEnd;
  end
endmodule

// File: rtl/dbrk_watch.sv
module dbrk_watch
  import dbrk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [2:0]        accSize,
  input  logic [ADDR_W-1:0] accAddr,
  output logic [ADDR_W-1:0] adjAddr,
  output logic              hit,
  output logic              trapFlag
);
  dpStrobe_t strobe;
  logic      addrMatch;

  dbrk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgBits(cfgWrData[3:0]), .accValid(accValid), .accWrite(accWrite),
    .addrMatch(addrMatch), .strobe(strobe), .hit(hit), .trapFlag(trapFlag)
  );

  dbrk_datapath #(.ADDR_W(ADDR_W), .SIZE_W(3)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgWrData(cfgWrData),
    .accAddr(accAddr), .accSize(accSize), .addrMatch(addrMatch),
    .adjAddr(adjAddr)
  );
endmodule

// File: rtl/dbrk_watch_chk.sv
module dbrk_watch_chk (
  input logic clk,
  input logic rstN,
  input logic cfgWrEn,
  input logic cfgSel,
  input logic cfgClrBit,
  input logic accValid,
  input logic hit,
  input logic trapFlag
);
  // R7
  trap_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> trapFlag);
  // R7
  trap_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapFlag && !(cfgWrEn && cfgSel && cfgClrBit)) |=> trapFlag);
  // R7
  trap_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgSel && cfgClrBit && !hit) |=> !trapFlag);
  // R6
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> !hit);
  // R7
  trap_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trapFlag) |-> $past(hit));
endmodule

bind dbrk_watch dbrk_watch_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
  .cfgClrBit(cfgWrData[3]), .accValid(accValid), .hit(hit),
  .trapFlag(trapFlag)
);

// File: tb/dbrk_watch_test.sv
module dbrk_watch_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgSel = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic [2:0]  accSize = '0;
  logic [31:0] accAddr = '0;
  logic [31:0] adjAddr;
  logic        hit;
  logic        trapFlag;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  dbrk_watch uut (.*);

  always #5 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [2:0]  sz;
    logic [31:0] addr;
    logic        exp;
  } vec_t;

  localparam int NV = 12;
  // breakpoint 0x1000_0014, both enables on, little-endian
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 32'h1000_0014, 1'b1},
    '{1'b1, 3'd0, 32'h1000_0015, 1'b0},
    '{1'b0, 3'd1, 32'h1000_0015, 1'b1},
    '{1'b1, 3'd1, 32'h1000_0016, 1'b0},
    '{1'b1, 3'd2, 32'h1000_0017, 1'b1},
    '{1'b0, 3'd2, 32'h1000_0018, 1'b0},
    '{1'b0, 3'd3, 32'h1000_0010, 1'b1},
    '{1'b1, 3'd3, 32'h1000_0018, 1'b0},
    '{1'b0, 3'd4, 32'h1000_001C, 1'b1},
    '{1'b1, 3'd4, 32'h1000_0020, 1'b0},
    '{1'b0, 3'd0, 32'h2000_0014, 1'b0},
    '{1'b1, 3'd7, 32'h1000_0019, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic sel, input logic [31:0] data);
    @(negedge clk);
    accValid = 1'b0;
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgWrData = '0;
  endtask

  task automatic access(input logic wr, input logic [2:0] sz, input logic [31:0] addr);
    @(negedge clk);
    accValid = 1'b1; accWrite = wr; accSize = sz; accAddr = addr;
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    accValid = 1'b0;
    #2;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, enables off so address 0 does not hit
    check("R1 trap", {31'd0, trapFlag}, 32'd0);
    access(1'b0, 3'd0, 32'h0);
    check("R1 hit", {31'd0, hit}, 32'd0);
    idle();

    // R2: load breakpoint and both enables
    cfgWrite(1'b0, 32'h1000_0014);
    cfgWrite(1'b1, 32'h3);

    // R3 R8 table walk
    foreach (VECS[k]) begin
      access(VECS[k].wr, VECS[k].sz, VECS[k].addr);
      check($sformatf("R3 vec%0d hit", k), {31'd0, hit}, {31'd0, VECS[k].exp});
      check($sformatf("R8 vec%0d adj", k), adjAddr, VECS[k].addr);
    end
    idle();
    check("R7 trap after table", {31'd0, trapFlag}, 32'd1);
    repeat (3) idle();
    check("R7 sticky", {31'd0, trapFlag}, 32'd1);
    cfgWrite(1'b1, 32'hB);
    #2;
    check("R7 cleared", {31'd0, trapFlag}, 32'd0);

    // R6: matching address without valid
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0; accSize = 3'd0; accAddr = 32'h1000_0014;
    #2;
    check("R6 no valid", {31'd0, hit}, 32'd0);

    // R4: read enable only
    cfgWrite(1'b1, 32'h1);
    access(1'b1, 3'd0, 32'h1000_0014);
    check("R4 write blocked", {31'd0, hit}, 32'd0);
    idle();
    check("R4 trap untouched", {31'd0, trapFlag}, 32'd0);
    access(1'b0, 3'd0, 32'h1000_0014);
    check("R4 read hit", {31'd0, hit}, 32'd1);
    idle();
    check("R4 trap set", {31'd0, trapFlag}, 32'd1);
    cfgWrite(1'b1, 32'h8);

    // R5: write enable only
    cfgWrite(1'b1, 32'h2);
    access(1'b0, 3'd2, 32'h1000_0014);
    check("R5 read blocked", {31'd0, hit}, 32'd0);
    idle();
    check("R5 trap untouched", {31'd0, trapFlag}, 32'd0);
    access(1'b1, 3'd2, 32'h1000_0014);
    check("R5 write hit", {31'd0, hit}, 32'd1);
    idle();

    // R7: hit and clear in the same cycle, hit wins
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = 1'b1; cfgWrData = 32'hA;
    accValid = 1'b1; accWrite = 1'b1; accSize = 3'd0; accAddr = 32'h1000_0014;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgWrData = '0; accValid = 1'b0;
    #2;
    check("R7 set wins", {31'd0, trapFlag}, 32'd1);
    cfgWrite(1'b1, 32'hB);
    #2;
    check("R7 clear again", {31'd0, trapFlag}, 32'd0);

    // R9: big-endian with both enables
    cfgWrite(1'b1, 32'h7);
    access(1'b0, 3'd0, 32'h1000_0011);
    check("R9 byte adj", adjAddr, 32'h1000_0016);
    access(1'b0, 3'd1, 32'h1000_0013);
    check("R9 half adj", adjAddr, 32'h1000_0014);
    access(1'b0, 3'd2, 32'h1000_0016);
    check("R9 word adj", adjAddr, 32'h1000_0010);
    access(1'b0, 3'd3, 32'h1000_0015);
    check("R9 dword adj", adjAddr, 32'h1000_0010);
    access(1'b0, 3'd4, 32'h1000_001F);
    check("R9 quad adj", adjAddr, 32'h1000_0018);
    access(1'b0, 3'd0, 32'h1000_0013);
    check("R9 adj-equal no hit", {31'd0, hit}, 32'd0);
    access(1'b0, 3'd0, 32'h1000_0014);
    check("R9 issued hit", {31'd0, hit}, 32'd1);
    check("R9 issued adj", adjAddr, 32'h1000_0013);
    idle();

    finish();
  end
endmodule